// File: doc/BRIEF.md
# 10-bit Programmable PWM Generator

This block drives one pulse-width-modulated output pin from a free-running tick counter. Software programs a 10-bit period and a 10-bit active width through a small 8-bit register write port. The low eight bits of each value sit in their own register. The top two bits of both values share one extension register. A two-bit rate code picks how many main-clock cycles make up one tick.

A polarity bit chooses whether the active part of each period is driven high or low. A run bit starts the counter, or stops and clears it. Every time a period wraps, the block raises a one-cycle interrupt pulse.

New period and width values first land in staging registers. The running waveform takes them only at the next period boundary, so a write made while the output runs never shortens or stretches a pulse already under way. A shorter period gives a faster waveform with fewer width steps.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the counter is stopped, `pwmOut` is 0 and `periodIrq` is 0.
- R2: While running with rate code 0, the interval between successive `periodIrq` pulses is (P+1) clock cycles. P is the 10-bit period: address 1 holds P[7:0] and address 3 bits [1:0] hold P[9:8].
- R3: Within every period the output sits at its active level for (D+1) ticks. D is the 10-bit width: address 2 holds D[7:0] and address 3 bits [3:2] hold D[9:8].
- R4: The extension bits at address 3 take part in both the period and the width, so values above 255 give periods and widths longer than 256 ticks.
- R5: Control register (address 0) bit 1 is polarity. With 0 the active level is high. With 1 the active level is low, and a stopped output rests high.
- R6: Control bits [3:2] select the tick as 1, 2, 4 or 8 main-clock cycles for codes 0, 1, 2 and 3. Period and width scale by that factor.
- R7: When D is equal to or larger than P, the output stays at its active level for the whole period.
- R8: A write to the period or width registers while running leaves the current period unchanged and takes effect from the next period.
- R9: Clearing control bit 0 (run) drives the output to its inactive level within two cycles and stops all interrupt pulses. It also resets the count, so a restart gives a first full period of exactly (P+1) ticks.
- R10: `periodIrq` is a single-cycle pulse issued once per period end, and only while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 period low, 2 width low, 3 extension |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | PWM waveform |
| periodIrq | output | 1 | One-cycle pulse at each period end |

## Verification
The bench goes after the boundary cases of the width. A width equal to the period, or wider than it, must give a fully active period; a comparator that wraps or uses a strict compare would drop a tick or give a zero-width pulse. Writes made in the middle of a period must leave that period alone; a design without staging would show a truncated or stretched pulse. A stop made in mid-period must restart from zero; a counter that is only paused would deliver a short first period. Extension-bit values above 255 and the slow rate codes catch mis-sliced high bits and wrong prescaler masks.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  // Register map of the write port
  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_PER_LO  = 2'd1,
    ADDR_DUTY_LO = 2'd2,
    ADDR_EXT     = 2'd3
  } regAddr_e;

  // Control register field positions
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_POL_BIT = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int SEL_W        = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // advance the counter this cycle
    logic clear;  // hold counter at zero, output inactive
    logic load;   // period end: wrap and take staged values
    logic pol;    // 1 = active level is low
  } pwmStrobe_t;

endpackage

// File: rtl/pwm10_ctrl.sv
module pwm10_ctrl
  import pwm10_pkg::*;
#(
  parameter int LOW_W     = 8,
  parameter int HIGH_W    = 2,
  parameter int SEL_SHIFT = 1,
  localparam int CNT_W    = LOW_W + HIGH_W,
  localparam int PRE_W    = ((1 << SEL_W) - 1) * SEL_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [LOW_W-1:0] wrData,
  input  logic             atEnd,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] perStaged,
  output logic [CNT_W-1:0] dutyStaged,
  output logic             runBit,
  output logic             periodIrq
);

  logic              runQ;
  logic              polQ;
  logic [SEL_W-1:0]  selQ;
  logic [LOW_W-1:0]  perLoQ;
  logic [LOW_W-1:0]  dutyLoQ;
  logic [HIGH_W-1:0] perHiQ;
  logic [HIGH_W-1:0] dutyHiQ;
  logic [PRE_W-1:0]  preQ;
  logic [PRE_W-1:0]  preMask;
  logic              tickNow;
  logic              loadNow;
  logic              irqQ;
  regAddr_e          addrSel;

  assign addrSel = regAddr_e'(wrAddr);

  // Register write decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      polQ    <= 1'b0;
      selQ    <= '0;
      perLoQ  <= '0;
      dutyLoQ <= '0;
      perHiQ  <= '0;
      dutyHiQ <= '0;
    end else if (wrEn) begin
      unique case (addrSel)
        ADDR_CTRL: begin
          runQ <= wrData[CTRL_RUN_BIT];
          polQ <= wrData[CTRL_POL_BIT];
          selQ <= wrData[CTRL_SEL_LSB +: SEL_W];
        end
        ADDR_PER_LO:  perLoQ  <= wrData;
        ADDR_DUTY_LO: dutyLoQ <= wrData;
        ADDR_EXT: begin
          perHiQ  <= wrData[0 +: HIGH_W];
          dutyHiQ <= wrData[HIGH_W +: HIGH_W];
        end
        default: ;
      endcase
    end
  end

  assign perStaged  = {perHiQ, perLoQ};
  assign dutyStaged = {dutyHiQ, dutyLoQ};

  // Prescaler mask: the low sel*SEL_SHIFT bits must all be set for a tick
  always_comb begin
    int shiftAmt;
    shiftAmt = int'(selQ) * SEL_SHIFT;
    for (int b = 0; b < PRE_W; b++) begin
      preMask[b] = (b < shiftAmt);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (!runQ) begin
      preQ <= '0;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end

  assign tickNow = runQ && ((preQ & preMask) == preMask);
  assign loadNow = tickNow && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else begin
      irqQ <= loadNow;
    end
  end

  assign strobe.tick  = tickNow;
  assign strobe.clear = !runQ;
  assign strobe.load  = loadNow;
  assign strobe.pol   = polQ;
  assign runBit       = runQ;
  assign periodIrq    = irqQ;

endmodule

// File: rtl/pwm10_dp.sv
module pwm10_dp
  import pwm10_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] perStaged,
  input  logic [CNT_W-1:0] dutyStaged,
  output logic             atEnd,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] perW,
  output logic [CNT_W-1:0] dutyW
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] perQ;
  logic [CNT_W-1:0] dutyQ;
  logic             outQ;
  logic             inActive;

  assign atEnd    = (cntQ == perQ);
  assign inActive = (cntQ <= dutyQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      perQ  <= '0;
      dutyQ <= '0;
      outQ  <= 1'b0;
    end else if (strobe.clear) begin
      cntQ  <= '0;
      perQ  <= perStaged;
      dutyQ <= dutyStaged;
      outQ  <= strobe.pol;
    end else begin
      if (strobe.load) begin
        cntQ  <= '0;
        perQ  <= perStaged;
        dutyQ <= dutyStaged;
      end else if (strobe.tick) begin
        cntQ <= cntQ + 1'b1;
      end
      outQ <= inActive ^ strobe.pol;
    end
  end

  assign pwmOut = outQ;
  assign cnt    = cntQ;
  assign perW   = perQ;
  assign dutyW  = dutyQ;

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int LOW_W     = 8,
  parameter int HIGH_W    = 2,
  parameter int SEL_SHIFT = 1,
  localparam int CNT_W    = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [LOW_W-1:0] wrData,
  output logic             pwmOut,
  output logic             periodIrq
);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] perStaged;
  logic [CNT_W-1:0] dutyStaged;
  logic             atEnd;
  logic             runBit;
  logic             polBit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perW;
  logic [CNT_W-1:0] dutyW;

  pwm10_ctrl #(
    .LOW_W(LOW_W), .HIGH_W(HIGH_W), .SEL_SHIFT(SEL_SHIFT)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .atEnd(atEnd), .strobe(strobe), .perStaged(perStaged),
    .dutyStaged(dutyStaged), .runBit(runBit), .periodIrq(periodIrq)
  );

  pwm10_dp #(.CNT_W(CNT_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .perStaged(perStaged),
    .dutyStaged(dutyStaged), .atEnd(atEnd), .pwmOut(pwmOut),
    .cnt(cnt), .perW(perW), .dutyW(dutyW)
  );

  assign polBit = strobe.pol;

endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmOut,
  input logic             periodIrq,
  input logic             runBit,
  input logic             polBit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] perW,
  input logic [CNT_W-1:0] dutyW
);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runBit |-> (cnt <= perW));

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && (dutyW >= perW)) |=> (pwmOut == !$past(polBit)));

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runBit) && !$stable(dutyW)) |-> (cnt == '0));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> (cnt == '0));

  // R9
  stop_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> (pwmOut == $past(polBit)));

  // R10
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |-> $past(runBit));

  // R10
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |-> (cnt == '0));

endmodule

bind pwm10_gen pwm10_chk #(.CNT_W(LOW_W + HIGH_W)) chkInst (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .periodIrq(periodIrq),
  .runBit(runBit), .polBit(polBit), .cnt(cnt), .perW(perW), .dutyW(dutyW)
);

// File: tb/pwm10_gen_test.sv
module pwm10_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut;
  logic       periodIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm10_gen uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .periodIrq(periodIrq)
  );

  always #4 clk = ~clk;

  // {sel[2], pol[1], period[10], duty[10], expClocks[12], expActive[12]}
  localparam int NV = 9;
  localparam logic [46:0] VECS [NV] = '{
    {2'd0, 1'b0, 10'd9,     10'd3,     12'd10,   12'd4},
    {2'd0, 1'b1, 10'd9,     10'd3,     12'd10,   12'd4},
    {2'd1, 1'b0, 10'd5,     10'd2,     12'd12,   12'd6},
    {2'd2, 1'b0, 10'd4,     10'd0,     12'd20,   12'd4},
    {2'd3, 1'b0, 10'd3,     10'd1,     12'd32,   12'd16},
    {2'd0, 1'b0, 10'd9,     10'd9,     12'd10,   12'd10},
    {2'd0, 1'b0, 10'd4,     10'd7,     12'd5,    12'd5},
    {2'd0, 1'b0, 10'h105,   10'h080,   12'd262,  12'd129},
    {2'd0, 1'b0, 10'h3FF,   10'h080,   12'd1024, 12'd129}
  };

  function automatic string vecTag(int i);
    case (i)
      1:       return "R5";
      2, 3, 4: return "R6";
      5, 6:    return "R7";
      7, 8:    return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic pol,
                     input logic [9:0] per, input logic [9:0] duty);
    wr(2'd0, {4'b0, sel, pol, 1'b0});
    wr(2'd1, per[7:0]);
    wr(2'd2, duty[7:0]);
    wr(2'd3, {4'b0, duty[9:8], per[9:8]});
    wr(2'd0, {4'b0, sel, pol, 1'b1});
  endtask

  task automatic waitIrq();
    int g = 0;
    do begin @(negedge clk); g++; end while (!periodIrq && g < 5000);
  endtask

  task automatic measure(input logic actLvl, output int n, output int act);
    waitIrq();
    n = 0;
    act = 0;
    do begin
      @(negedge clk);
      n++;
      if (pwmOut == actLvl) act++;
    end while (!periodIrq && n < 5000);
  endtask

  // Write one register right after a period end, then measure that period and the next
  task automatic midWrite(input logic [1:0] a, input logic [7:0] d,
                          input int curN, input int curAct,
                          input int nxtN, input int nxtAct, input string tag);
    int n;
    int act;
    waitIrq();
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    n = 0;
    act = 0;
    do begin
      @(negedge clk);
      wrEn = 1'b0;
      n++;
      if (pwmOut) act++;
    end while (!periodIrq && n < 5000);
    check(n == curN, {tag, " current period"}, n, curN);
    check(act == curAct, {tag, " current width"}, act, curAct);
    n = 0;
    act = 0;
    do begin
      @(negedge clk);
      n++;
      if (pwmOut) act++;
    end while (!periodIrq && n < 5000);
    check(n == nxtN, {tag, " next period"}, n, nxtN);
    check(act == nxtAct, {tag, " next width"}, act, nxtAct);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int act;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, nothing toggles while stopped
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (pwmOut !== 1'b0 || periodIrq !== 1'b0) bad++;
    end
    check(bad == 0, "R1 idle after reset", bad, 0);

    // Table of configurations: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VECS[i];
      cfg(v[46:45], v[44], v[43:34], v[33:24]);
      measure(!v[44], n, act);
      check(n == int'(v[23:12]), {vecTag(i), " period clocks"}, n, int'(v[23:12]));
      check(act == int'(v[11:0]), {vecTag(i), " R3 active clocks"}, act, int'(v[11:0]));
    end

    // R8: staged writes wait for the period boundary
    cfg(2'd0, 1'b0, 10'd9, 10'd3);
    midWrite(2'd2, 8'd7, 10, 4, 10, 8, "R8 width");
    cfg(2'd0, 1'b0, 10'd9, 10'd3);
    midWrite(2'd1, 8'd4, 10, 4, 5, 4, "R8 period");

    // R9: stop in mid-period, output inactive, no pulses
    cfg(2'd0, 1'b0, 10'd9, 10'd9);
    waitIrq();
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h00);
    @(negedge clk);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (pwmOut !== 1'b0 || periodIrq !== 1'b0) bad++;
    end
    check(bad == 0, "R9 stopped output and irq", bad, 0);

    // R9: restart gives a full first period (counter was cleared)
    wr(2'd0, 8'h01);
    n = 0;
    do begin @(negedge clk); n++; end while (!periodIrq && n < 5000);
    check(n == 10, "R9 first period after restart", n, 10);

    // R10: irq lasts exactly one cycle
    @(negedge clk);
    check(periodIrq == 1'b0, "R10 single-cycle pulse", periodIrq, 0);

    // R5: stopped with inverted polarity rests high
    wr(2'd0, 8'h02);
    repeat (2) @(negedge clk);
    check(pwmOut == 1'b1, "R5 inactive level with polarity 1", pwmOut, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule